// File: doc/BRIEF.md
# Programmable-format UART transceiver

This block is a full-duplex asynchronous serial port for a CPU. Software writes characters into a single transmit holding register and reads received characters from a receive data register. A status byte reports whether the transmitter can take another character, whether the whole transmit path is drained, whether a character is waiting, and whether anything went wrong on reception. Both serial lines rest high between characters.

The character format is set at run time through a mode byte. It sets the character length (five to eight bits), whether a parity bit is added and checked, whether that parity is even or odd, and how long the stop period lasts (one, one and a half, or two bit times). Bit timing comes from a 16x oversampling tick. The tick is derived from the system clock by a divisor input, so one bit lasts sixteen divisor periods. The receiver confirms a start bit at its midpoint and samples every later bit at its centre.

Top module: `uart_xcvr`

## Requirements
- R1: `txLine` is high when idle. A transmitted character is a low start bit, then the data bits least-significant first, then the parity bit when enabled, then a high stop period.
- R2: `modeIn[1:0]` selects the character length as 5 + code. Transmit data bits above that length are not sent. Received characters appear right-aligned in `rxData`, with the unused upper bits at zero.
- R3: `modeIn[2]` enables parity and `modeIn[3]` selects odd (1) or even (0). Even parity makes the number of ones across data and parity bits even. Odd parity makes it odd.
- R4: `modeIn[5:4]` sets the stop period: 00 gives 1 bit, 01 gives 1.5 bits, 10 or 11 gives 2 bits. When characters are written back to back, consecutive start edges are (16·(1+length+parityEnable) + 8·halfBits) tick periods apart, where halfBits is 2, 3 or 4.
- R5: One tick period lasts `divisor` clock cycles, and a divisor of 0 behaves as 1. One bit lasts 16 ticks.
- R6: `status[0]` (transmit ready) is high when the holding register is free. `status[2]` (transmit empty) is high when both the holding register and the shifter are idle. A write while `status[0]` is low is ignored. `status[7:6]` read zero, and the reset value of `status` is 8'h05.
- R7: `status[1]` (receive ready) rises when a character has been received into `rxData`, and a pulse on `rxRe` clears it.
- R8: `status[4]` (overrun) is set when a character completes while `status[1]` is still high. The newer character replaces the older one in `rxData`.
- R9: `status[3]` (parity error) is set when the received parity does not match the enabled sense. `status[5]` (framing error) is set when the stop bit samples low. A pulse on `statRe` clears bits 3, 4 and 5.
- R10: A low pulse on `rxLine` that ends before the midpoint of a start bit is discarded. The receiver returns to idle and delivers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Clock cycles per oversampling tick (0 acts as 1) |
| modeWe | input | 1 | Load `modeIn` into the mode register |
| modeIn | input | 8 | Format: [1:0] length-5, [2] parity on, [3] odd, [5:4] stop |
| txWe | input | 1 | Write `txData` into the holding register |
| txData | input | 8 | Character to transmit |
| rxRe | input | 1 | Read strobe for `rxData`; clears receive ready |
| rxData | output | 8 | Last received character, right-aligned |
| statRe | input | 1 | Status read strobe; clears error bits |
| status | output | 8 | {2'b0, framing, overrun, parity, txEmpty, rxReady, txReady} |
| rxLine | input | 1 | Serial receive line, idle high |
| txLine | output | 1 | Serial transmit line, idle high |

## Verification
The embedded properties assume two things. First, the mode byte and the divisor are rewritten only while both directions are idle. Second, the receive line is driven in whole bit periods, so the oversampled counters never see a format change in the middle of a character. The stimulus respects this. It reprograms the format only after the transmitter reports empty and the looped-back receiver has delivered its last character. Its hand-built receive frames hold every level for exactly sixteen ticks, except for a shortened low stop level and a deliberate short glitch. The sweep covers every length, parity choice and stop length with three divisor values, and compares line levels and spacing against arithmetic expectations.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    LnIdle, LnStart, LnData, LnParity, LnStop
  } phase_e;

  typedef struct packed {
    logic [1:0] stopCode;
    logic       parOdd;
    logic       parEn;
    logic [1:0] lenCode;
  } mode_t;

  typedef struct packed {
    logic   tick;
    logic   txLoad;
    logic   txShift;
    phase_e txSel;
    logic   txBusy;
    logic   rxShift;
    logic   rxParSample;
    logic   rxDeliver;
  } dpCtl_t;

  typedef struct packed {
    logic holdFull;
    logic rxBit;
  } dpStat_t;
endpackage

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  mode_t            mode,
  input  dpStat_t          st,
  output dpCtl_t           ctl
);
  localparam int CNT_W = $clog2(2 * OVS);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVS / 2 - 1);

  logic [DIV_W-1:0] divCnt, divEff;
  logic             tick;

  phase_e           txState, rxState;
  logic [CNT_W-1:0] txCnt, rxCnt, stopLast;
  logic [2:0]       txBit, rxBit, lenM1;
  logic             txLoad, txShift, rxShift, rxParSample, rxDeliver;

  // tick generator
  assign divEff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick   = (divCnt >= divEff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= tick ? '0 : divCnt + DIV_W'(1);
  end

  assign lenM1 = 3'(3'd4 + {1'b0, mode.lenCode});

  always_comb begin
    unique case (mode.stopCode)
      2'b00:   stopLast = CNT_W'(OVS - 1);
      2'b01:   stopLast = CNT_W'(OVS + OVS / 2 - 1);
      default: stopLast = CNT_W'(2 * OVS - 1);
    endcase
  end

  // transmit sequencing
  assign txLoad  = tick && st.holdFull &&
                   ((txState == LnIdle) || (txState == LnStop && txCnt == stopLast));
  assign txShift = tick && (txState == LnData) && (txCnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= LnIdle;
      txCnt   <= '0;
      txBit   <= '0;
    end else if (tick) begin
      unique case (txState)
        LnIdle: begin
          txCnt <= '0;
          if (txLoad) txState <= LnStart;
        end
        LnStart: begin
          if (txCnt == BIT_LAST) begin
            txCnt   <= '0;
            txBit   <= '0;
            txState <= LnData;
          end else txCnt <= txCnt + 1'b1;
        end
        LnData: begin
          if (txCnt == BIT_LAST) begin
            txCnt <= '0;
            if (txBit == lenM1) txState <= mode.parEn ? LnParity : LnStop;
            else                txBit   <= txBit + 1'b1;
          end else txCnt <= txCnt + 1'b1;
        end
        LnParity: begin
          if (txCnt == BIT_LAST) begin
            txCnt   <= '0;
            txState <= LnStop;
          end else txCnt <= txCnt + 1'b1;
        end
        default: begin
          if (txCnt == stopLast) begin
            txCnt   <= '0;
            txState <= txLoad ? LnStart : LnIdle;
          end else txCnt <= txCnt + 1'b1;
        end
      endcase
    end
  end

  // receive sequencing
  assign rxShift     = tick && (rxState == LnData)   && (rxCnt == BIT_LAST);
  assign rxParSample = tick && (rxState == LnParity) && (rxCnt == BIT_LAST);
  assign rxDeliver   = tick && (rxState == LnStop)   && (rxCnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= LnIdle;
      rxCnt   <= '0;
      rxBit   <= '0;
    end else if (tick) begin
      unique case (rxState)
        LnIdle: begin
          rxCnt <= '0;
          if (!st.rxBit) rxState <= LnStart;
        end
        LnStart: begin
          if (rxCnt == MID_LAST) begin
            rxCnt   <= '0;
            rxBit   <= '0;
            rxState <= st.rxBit ? LnIdle : LnData;
          end else rxCnt <= rxCnt + 1'b1;
        end
        LnData: begin
          if (rxCnt == BIT_LAST) begin
            rxCnt <= '0;
            if (rxBit == lenM1) rxState <= mode.parEn ? LnParity : LnStop;
            else                rxBit   <= rxBit + 1'b1;
          end else rxCnt <= rxCnt + 1'b1;
        end
        LnParity: begin
          if (rxCnt == BIT_LAST) begin
            rxCnt   <= '0;
            rxState <= LnStop;
          end else rxCnt <= rxCnt + 1'b1;
        end
        default: begin
          if (rxCnt == BIT_LAST) begin
            rxCnt   <= '0;
            rxState <= LnIdle;
          end else rxCnt <= rxCnt + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ctl.tick        = tick;
    ctl.txLoad      = txLoad;
    ctl.txShift     = txShift;
    ctl.txSel       = txState;
    ctl.txBusy      = (txState != LnIdle);
    ctl.rxShift     = rxShift;
    ctl.rxParSample = rxParSample;
    ctl.rxDeliver   = rxDeliver;
  end

  // R2: data bit index never passes the programmed length
  a_r2_tx_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    (txState == LnData) |-> (txBit <= lenM1));
  a_r2_rx_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == LnData) |-> (rxBit <= lenM1));
  // R10: a start that fails its midpoint check returns straight to idle
  a_r10_glitch_drop: assert property (@(posedge clk) disable iff (!rstN)
    (tick && rxState == LnStart && rxCnt == MID_LAST && st.rxBit) |=> (rxState == LnIdle));
endmodule

// File: rtl/uart_dp.sv
module uart_dp
  import uart_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [7:0]        modeIn,
  input  logic              txWe,
  input  logic [CHAR_W-1:0] txData,
  input  logic              rxRe,
  input  logic              statRe,
  input  logic              rxLine,
  input  dpCtl_t            ctl,
  output dpStat_t           st,
  output mode_t             mode,
  output logic [CHAR_W-1:0] rxData,
  output logic [7:0]        status,
  output logic              txLine
);
  mode_t             modeR;
  logic [CHAR_W-1:0] holdR, txSh, rxSh, charMask, rxAligned;
  logic              holdFull, txParBit, rxParBit;
  logic              rxMeta, rxSync;
  logic              rxReady, parErr, overrun, frameErr;
  logic [1:0]        shAmt;
  logic              parSet, ovrSet, frmSet;

  always_ff @(posedge clk) begin
    if (!rstN)       modeR <= '0;
    else if (modeWe) modeR <= mode_t'(modeIn[5:0]);
  end
  assign mode = modeR;

  assign shAmt     = 2'(2'd3 - modeR.lenCode);
  assign charMask  = {CHAR_W{1'b1}} >> shAmt;
  assign rxAligned = rxSh >> shAmt;

  // transmit holding register and shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdR    <= '0;
      holdFull <= 1'b0;
      txSh     <= '0;
      txParBit <= 1'b0;
    end else begin
      if (ctl.txLoad) begin
        holdFull <= 1'b0;
        txSh     <= holdR & charMask;
        txParBit <= (^(holdR & charMask)) ^ modeR.parOdd;
      end else begin
        if (txWe && !holdFull) begin
          holdR    <= txData;
          holdFull <= 1'b1;
        end
        if (ctl.txShift) txSh <= txSh >> 1;
      end
    end
  end

  always_comb begin
    unique case (ctl.txSel)
      LnStart:  txLine = 1'b0;
      LnData:   txLine = txSh[0];
      LnParity: txLine = txParBit;
      default:  txLine = 1'b1;
    endcase
  end

  // receive synchroniser, shifter and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  assign parSet = ctl.rxDeliver && modeR.parEn && ((^rxAligned) ^ rxParBit ^ modeR.parOdd);
  assign ovrSet = ctl.rxDeliver && rxReady && !rxRe;
  assign frmSet = ctl.rxDeliver && !rxSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh     <= '0;
      rxParBit <= 1'b0;
      rxData   <= '0;
      rxReady  <= 1'b0;
      parErr   <= 1'b0;
      overrun  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (ctl.rxShift)     rxSh     <= {rxSync, rxSh[CHAR_W-1:1]};
      if (ctl.rxParSample) rxParBit <= rxSync;
      if (ctl.rxDeliver) begin
        rxData  <= rxAligned;
        rxReady <= 1'b1;
      end else if (rxRe) rxReady <= 1'b0;
      parErr   <= (parErr   && !statRe) || parSet;
      overrun  <= (overrun  && !statRe) || ovrSet;
      frameErr <= (frameErr && !statRe) || frmSet;
    end
  end

  assign st.holdFull = holdFull;
  assign st.rxBit    = rxSync;
  assign status = {2'b00, frameErr, overrun, parErr, (!holdFull && !ctl.txBusy), rxReady, !holdFull};

  // R1: the line only moves on an oversampling tick
  a_r1_line_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.tick |=> $stable(txLine));
  // R6: empty implies ready; a load only takes a full holding register
  a_r6_empty_implies_ready: assert property (@(posedge clk) disable iff (!rstN)
    status[2] |-> status[0]);
  a_r6_load_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txLoad |-> holdFull);
  // R7: a read with no new character clears receive ready
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rxRe && !ctl.rxDeliver) |=> !status[1]);
  // R8: completion over an unread character flags overrun
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rxDeliver && status[1] && !rxRe) |=> status[4]);
  // R9: status read with no completion clears all error bits
  a_r9_read_clears_errors: assert property (@(posedge clk) disable iff (!rstN)
    (statRe && !ctl.rxDeliver) |=> (status[5:3] == 3'b000));
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             modeWe,
  input  logic [7:0]       modeIn,
  input  logic             txWe,
  input  logic [7:0]       txData,
  input  logic             rxRe,
  output logic [7:0]       rxData,
  input  logic             statRe,
  output logic [7:0]       status,
  input  logic             rxLine,
  output logic             txLine
);
  dpCtl_t  ctl;
  dpStat_t st;
  mode_t   mode;

  uart_ctrl #(.OVS(OVS), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .divisor(divisor), .mode(mode), .st(st), .ctl(ctl)
  );

  uart_dp u_dp (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeIn(modeIn),
    .txWe(txWe), .txData(txData), .rxRe(rxRe), .statRe(statRe),
    .rxLine(rxLine), .ctl(ctl), .st(st), .mode(mode),
    .rxData(rxData), .status(status), .txLine(txLine)
  );
endmodule

// File: tb/uart_xcvr_bench.sv
`timescale 1ns/1ps
module uart_xcvr_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic        modeWe = 1'b0, txWe = 1'b0, rxRe = 1'b0, statRe = 1'b0;
  logic [7:0]  modeIn = 8'h00, txData = 8'h00;
  logic [7:0]  rxData, status;
  logic        txLine, rxLine;
  logic        loopOn = 1'b1, rxDrive = 1'b1;
  int          cyc = 0, checks = 0, errors = 0;

  assign rxLine = loopOn ? txLine : rxDrive;

  uart_xcvr u_uart_xcvr (
    .clk(clk), .rstN(rstN), .divisor(divisor), .modeWe(modeWe), .modeIn(modeIn),
    .txWe(txWe), .txData(txData), .rxRe(rxRe), .rxData(rxData),
    .statRe(statRe), .status(status), .rxLine(rxLine), .txLine(txLine)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulseWrite(input logic [7:0] d);
    @(negedge clk); txData = d; txWe = 1'b1;
    @(negedge clk); txWe = 1'b0;
  endtask

  task automatic setMode(input logic [7:0] m);
    @(negedge clk); modeIn = m; modeWe = 1'b1;
    @(negedge clk); modeWe = 1'b0;
  endtask

  task automatic readRx;
    @(negedge clk); rxRe = 1'b1;
    @(negedge clk); rxRe = 1'b0;
  endtask

  task automatic readStat;
    @(negedge clk); statRe = 1'b1;
    @(negedge clk); statRe = 1'b0;
  endtask

  task automatic waitFall(output int t);
    @(negedge clk);
    while (txLine !== 1'b0) @(negedge clk);
    t = cyc;
  endtask

  task automatic waitStatus(input int bitIdx);
    @(negedge clk);
    while (status[bitIdx] !== 1'b1) @(negedge clk);
  endtask

  // drive one frame on rxLine at divisor 1 (16 clocks per bit)
  task automatic sendRx(input logic [7:0] d, input int len, input bit pe,
                        input bit pbit, input bit stopLvl);
    @(negedge clk); rxDrive = 1'b0; waitClk(16);
    for (int k = 0; k < len; k++) begin rxDrive = d[k]; waitClk(16); end
    if (pe) begin rxDrive = pbit; waitClk(16); end
    rxDrive = stopLvl; waitClk(stopLvl ? 16 : 12);
    rxDrive = 1'b1; waitClk(40);
  endtask

  task automatic runCfg(input int lc, input int pm, input int sc, input int dv);
    int len, pe, po, eff, halves, t0, t1, expGap;
    logic [7:0] a, b, mask;
    len = 5 + lc; pe = (pm != 0); po = (pm == 2);
    eff = (dv == 0) ? 1 : dv;
    halves = (sc == 0) ? 2 : (sc == 1) ? 3 : 4;
    mask = 8'hFF >> (8 - len);
    a = 8'(8'hA5 ^ (lc * 37 + pm * 11 + sc * 5));
    b = ~a;
    divisor = 16'(dv);
    setMode({2'b00, 2'(sc), 1'(po), 1'(pe), 2'(lc)});
    pulseWrite(a);
    waitFall(t0);
    pulseWrite(b);
    for (int k = 0; k < len; k++) begin
      waitUntil(t0 + (16 * (k + 1) + 8) * eff);
      check(txLine == a[k], "R2 data bit LSB first", txLine, a[k]);
    end
    if (pe != 0) begin
      waitUntil(t0 + (16 * (len + 1) + 8) * eff);
      check(txLine == ((^(a & mask)) ^ po[0]), "R3 parity bit", txLine, (^(a & mask)) ^ po[0]);
    end
    waitUntil(t0 + (16 * (1 + len + pe) + 4) * eff);
    check(txLine == 1'b1, "R1 stop level high", txLine, 1);
    waitFall(t1);
    expGap = (16 * (1 + len + pe) + 8 * halves) * eff;
    check((t1 - t0) == expGap, "R4/R5 frame spacing", t1 - t0, expGap);
    check(status[1] == 1'b1 && rxData == (a & mask), "R7 loopback first char", rxData, a & mask);
    readRx();
    waitStatus(2);
    waitClk(20 * eff + 4);
    check(status[1] == 1'b1 && rxData == (b & mask), "R2 loopback second char", rxData, b & mask);
    check(status[5:3] == 3'b000, "R9 no errors on clean frames", status[5:3], 0);
    readRx();
    readStat();
  endtask

  initial begin
    waitClk(3);
    check(status == 8'h05, "R6 reset status", status, 8'h05);
    check(txLine == 1'b1, "R1 idle line high", txLine, 1);
    rstN = 1'b1;
    waitClk(3);

    for (int lc = 0; lc < 4; lc++)
      for (int pm = 0; pm < 3; pm++)
        for (int sc = 0; sc < 3; sc++)
          runCfg(lc, pm, sc, (lc * 9 + pm * 3 + sc) % 3 == 2 ? 0 : 1 + (lc * 9 + pm * 3 + sc) % 3);

    // receive-side directed frames: 8 bits, even parity, 1 stop, divisor 1
    divisor = 16'd1;
    loopOn = 1'b0;
    setMode(8'h07);
    sendRx(8'h3C, 8, 1'b1, 1'b0, 1'b1);
    check(status == 8'h07, "R7 receive ready set", status, 8'h07);
    check(rxData == 8'h3C, "R7 received data", rxData, 8'h3C);
    readRx();
    check(status[1] == 1'b0, "R7 read clears ready", status[1], 0);

    sendRx(8'h81, 8, 1'b1, 1'b1, 1'b1);
    check(status[3] == 1'b1, "R9 parity error set", status[3], 1);
    readRx(); readStat();
    check(status[3] == 1'b0, "R9 parity error cleared by status read", status[3], 0);

    sendRx(8'h55, 8, 1'b1, 1'b0, 1'b0);
    check(status[5] == 1'b1, "R9 framing error set", status[5], 1);
    readRx(); readStat();
    check(status[5] == 1'b0, "R9 framing error cleared", status[5], 0);

    sendRx(8'h11, 8, 1'b1, 1'b0, 1'b1);
    sendRx(8'h22, 8, 1'b1, 1'b0, 1'b1);
    check(status[4] == 1'b1, "R8 overrun set", status[4], 1);
    check(rxData == 8'h22, "R8 newer char kept", rxData, 8'h22);
    readRx(); readStat();
    check(status[4] == 1'b0, "R8 overrun cleared by status read", status[4], 0);

    @(negedge clk); rxDrive = 1'b0; waitClk(4); rxDrive = 1'b1; waitClk(60);
    check(status[1] == 1'b0, "R10 short glitch discarded", status[1], 0);

    // holding register: write while not ready is ignored
    loopOn = 1'b1;
    setMode(8'h03);
    pulseWrite(8'h5A);
    waitStatus(0);
    pulseWrite(8'hC3);
    check(status[0] == 1'b0 && status[2] == 1'b0, "R6 busy flags", status[2:0], 0);
    pulseWrite(8'hFF);
    waitStatus(1);
    check(rxData == 8'h5A, "R6 first char", rxData, 8'h5A);
    readRx();
    waitStatus(1);
    check(rxData == 8'hC3, "R6 second char", rxData, 8'hC3);
    readRx();
    waitStatus(2);
    waitClk(400);
    check(status[1] == 1'b0, "R6 write while full ignored", status[1], 0);
    check(status[7:6] == 2'b00, "R6 upper status bits zero", status[7:6], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitClk(190000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule